// File: doc/BRIEF.md
# Nonlinear Three-Register Word Mixer

This block is the nonlinear core of a word-oriented stream cipher. It holds three 32-bit state registers and, every cycle, combines two words taken from an external shift register (the tap at position 5 and the tap at position 15) with that state. The combined result is a 32-bit output word. When the enable is high, the three registers advance together. The first register takes a modular sum. The second and third take the outputs of two different 32-bit substitution functions, each applied to the register before it in the chain.

Each substitution function works in two steps. First it replaces every byte of the input word through a 256-entry byte table. Then it mixes the four substituted bytes with a fixed circulant matrix over GF(2^8). The two functions use different byte tables and different reduction constants. Both tables are produced inside the block from their algebraic definitions, so no table contents have to be loaded.

The output word is combinational. A parent can consume it in the same cycle in which it raises the enable, before the registers move. The shift register and the sequencing of the cipher phases are handled outside this block.

Top module: `nl_fsm`

## Requirements
- R1: After `rst_ni` is released, all three state registers are zero, so `f_o` equals `s15_i`.
- R2: `f_o` = ((`s15_i` + A) mod 2^32) XOR B, where A and B are the current first and second registers. It is combinational and valid in the cycle in which the inputs are presented.
- R3: On an enabled cycle, the first register becomes (B + (C XOR `s5_i`)) mod 2^32, where C is the third register. All right-hand sides use the values from before the edge.
- R4: On an enabled cycle, the second register becomes the first substitution function of the old first register.
- R5: On an enabled cycle, the third register becomes the second substitution function of the old second register.
- R6: The first substitution function uses the AES forward byte table and the reduction polynomial x^8+x^4+x^3+x+1 (constant 0x1B). Byte 0 is bits 31:24 and byte 3 is bits 7:0. Writing d for doubling and t for doubling XOR the byte, the output bytes from most to least significant are d0^s1^s2^t3, t0^d1^s2^s3, s0^t1^d2^s3 and s0^s1^t2^d3. A zero input word gives 0x63636363.
- R7: The second substitution function uses the same mixing with constant 0x69. Its byte table is the degree-49 Dickson polynomial over GF(2^8) mod x^8+x^6+x^5+x^3+1, XOR 0x25. Table entries: 0x00 gives 0x25, 0x01 gives 0x24, 0x02 gives 0x73, 0xFF gives 0x86.
- R8: With `en_i` low and `clear_i` low, the state does not change.
- R9: `clear_i` zeroes all three registers at the next edge and takes priority over `en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of the state, overrides enable |
| en_i | input | 1 | Advance the state at the next edge |
| s5_i | input | 32 | Shift-register tap 5 |
| s15_i | input | 32 | Shift-register tap 15 |
| f_o | output | 32 | Output word |

## Verification
With both taps held at zero after a clear, the output words are fixed and known: 0x63636363 and then 0xEBEBEBEB. These values expose the zero-input entries of both byte tables, the byte order and the modular sum without any other input interfering. All-ones taps exercise the carry across the full 32-bit adder and the table entry at 0xFF. Seeded random taps, with randomly toggled enable and occasional clears, are compared every cycle against a reference model. That model builds its tables by an independent method: inverse search and squaring chains. The comparison separates a wrong table entry, a swapped byte lane, a wrong mixing coefficient and a wrong register rotation. Holding the enable low separates a frozen state from one that drifts, and a clear raised together with the enable checks which of the two wins.

// File: rtl/nlfsm_pkg.sv
package nlfsm_pkg;
  localparam int WORD_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int NBYTES   = WORD_W / BYTE_W;
  localparam logic [7:0] AES_POLY = 8'h1B;
  localparam logic [7:0] DKS_POLY = 8'h69;
  localparam logic [7:0] AES_AFF  = 8'h63;
  localparam logic [7:0] DKS_XOR  = 8'h25;
  // exponents of the degree-49 Dickson polynomial
  localparam logic [63:0] DKS_EXP = (64'd1 << 1) | (64'd1 << 9) | (64'd1 << 13) |
                                    (64'd1 << 15) | (64'd1 << 33) | (64'd1 << 41) |
                                    (64'd1 << 45) | (64'd1 << 47) | (64'd1 << 49);
  localparam int DKS_DEG = 49;

  typedef enum logic {BOX_AES, BOX_DKS} box_kind_e;

  function automatic logic [7:0] gf_dbl(logic [7:0] v, logic [7:0] p);
    return {v[6:0], 1'b0} ^ (v[7] ? p : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(logic [7:0] a, logic [7:0] b, logic [7:0] p);
    logic [7:0] r, x;
    r = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ x;
      x = gf_dbl(x, p);
    end
    return r;
  endfunction
endpackage

// File: rtl/sbox_byte.sv
module sbox_byte
  import nlfsm_pkg::*;
#(
  parameter box_kind_e KIND = BOX_AES
) (
  input  logic [7:0] a_i,
  output logic [7:0] y_o
);
  generate
    if (KIND == BOX_AES) begin : g_aes
      logic [7:0] inv, sq;
      always_comb begin
        // a^254 as product of a^(2^k), k=1..7
        sq  = a_i;
        inv = 8'h01;
        for (int k = 1; k < 8; k++) begin
          sq  = gf_mul(sq, sq, AES_POLY);
          inv = gf_mul(inv, sq, AES_POLY);
        end
        y_o = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
              {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ AES_AFF;
      end
    end else begin : g_dks
      logic [7:0] pw, acc;
      always_comb begin
        pw  = a_i;
        acc = 8'h00;
        for (int e = 1; e <= DKS_DEG; e++) begin
          if (DKS_EXP[e]) acc = acc ^ pw;
          pw = gf_mul(pw, a_i, DKS_POLY);
        end
        y_o = acc ^ DKS_XOR;
      end
    end
  endgenerate
endmodule

// File: rtl/word_sbox.sv
module word_sbox
  import nlfsm_pkg::*;
#(
  parameter box_kind_e  KIND = BOX_AES,
  parameter logic [7:0] POLY = AES_POLY
) (
  input  logic [WORD_W-1:0] w_i,
  output logic [WORD_W-1:0] y_o
);
  logic [7:0] s [NBYTES];
  logic [7:0] d [NBYTES];
  logic [7:0] t [NBYTES];
  logic [7:0] m [NBYTES];

  // lane 0 is the most significant byte
  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    sbox_byte #(.KIND(KIND)) u_sb (
      .a_i(w_i[WORD_W-1-BYTE_W*i -: BYTE_W]),
      .y_o(s[i])
    );
    assign d[i] = gf_dbl(s[i], POLY);
    assign t[i] = d[i] ^ s[i];
    assign y_o[WORD_W-1-BYTE_W*i -: BYTE_W] = m[i];
  end

  always_comb begin
    m[0] = d[0] ^ s[1] ^ s[2] ^ t[3];
    m[1] = t[0] ^ d[1] ^ s[2] ^ s[3];
    m[2] = s[0] ^ t[1] ^ d[2] ^ s[3];
    m[3] = s[0] ^ s[1] ^ t[2] ^ d[3];
  end
endmodule

// File: rtl/nl_fsm.sv
module nl_fsm
  import nlfsm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              en_i,
  input  logic [WORD_W-1:0] s5_i,
  input  logic [WORD_W-1:0] s15_i,
  output logic [WORD_W-1:0] f_o
);
  logic [WORD_W-1:0] r1_q, r2_q, r3_q;
  logic [WORD_W-1:0] s1_w, s2_w;

  word_sbox #(.KIND(BOX_AES), .POLY(AES_POLY)) u_s1 (.w_i(r1_q), .y_o(s1_w));
  word_sbox #(.KIND(BOX_DKS), .POLY(DKS_POLY)) u_s2 (.w_i(r2_q), .y_o(s2_w));

  assign f_o = (s15_i + r1_q) ^ r2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r1_q <= '0;
      r2_q <= '0;
      r3_q <= '0;
    end else if (clear_i) begin
      r1_q <= '0;
      r2_q <= '0;
      r3_q <= '0;
    end else if (en_i) begin
      r1_q <= r2_q + (r3_q ^ s5_i);
      r2_q <= s1_w;
      r3_q <= s2_w;
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (r1_q == '0 && r2_q == '0 && r3_q == '0)); // R9
  AST_HOLD_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !en_i) |=> ($stable(r1_q) && $stable(r2_q) && $stable(r3_q))); // R8
  AST_R1_MODSUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clear_i) |=> r1_q == $past(r2_q) + ($past(r3_q) ^ $past(s5_i))); // R3
  AST_R2_FROM_S1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clear_i) |=> r2_q == $past(s1_w)); // R4
  AST_R3_FROM_S2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clear_i) |=> r3_q == $past(s2_w)); // R5
endmodule

// File: tb/sim_nl_fsm.sv
module sim_nl_fsm;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clear_i = 1'b0;
  logic        en_i = 1'b0;
  logic [31:0] s5_i = '0;
  logic [31:0] s15_i = '0;
  logic [31:0] f_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0]  tbl1 [256];
  logic [7:0]  tbl2 [256];
  logic [31:0] m1, m2, m3;

  always #10 clk_i = ~clk_i;

  nl_fsm u0 (.*);

  function automatic logic [7:0] b_dbl(logic [7:0] v, logic [7:0] p);
    logic [7:0] r;
    r = v << 1;
    if (v[7]) r = r ^ p;
    return r;
  endfunction

  function automatic logic [7:0] b_mul(logic [7:0] a, logic [7:0] b, logic [7:0] p);
    logic [7:0] r;
    r = 0;
    for (int i = 7; i >= 0; i--) begin
      r = b_dbl(r, p);
      if (a[i]) r = r ^ b;
    end
    return r;
  endfunction

  function automatic logic [7:0] b_aes(logic [7:0] x);
    logic [7:0] v, o, c;
    v = 0;
    c = 8'h63;
    for (int y = 1; y < 256; y++)
      if (x != 0 && b_mul(x, 8'(y), 8'h1B) == 8'h01) v = 8'(y);
    for (int i = 0; i < 8; i++)
      o[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8] ^ c[i];
    return o;
  endfunction

  function automatic logic [7:0] b_dks(logic [7:0] x);
    logic [7:0] p, x2, x4, x8, x16, x32, x9, x13, x15, x33, x41, x45, x47, x49;
    p = 8'h69;
    x2 = b_mul(x, x, p);     x4 = b_mul(x2, x2, p);   x8 = b_mul(x4, x4, p);
    x16 = b_mul(x8, x8, p);  x32 = b_mul(x16, x16, p);
    x9 = b_mul(x8, x, p);    x13 = b_mul(x9, x4, p);  x15 = b_mul(x13, x2, p);
    x33 = b_mul(x32, x, p);  x41 = b_mul(x33, x8, p); x45 = b_mul(x41, x4, p);
    x47 = b_mul(x45, x2, p); x49 = b_mul(x47, x2, p);
    return x ^ x9 ^ x13 ^ x15 ^ x33 ^ x41 ^ x45 ^ x47 ^ x49 ^ 8'h25;
  endfunction

  function automatic logic [31:0] b_box(logic [31:0] w, bit second);
    logic [7:0] s [4];
    logic [7:0] o [4];
    logic [7:0] p, cf;
    p = second ? 8'h69 : 8'h1B;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] idx;
      idx = w[31-8*k -: 8];
      s[k] = second ? tbl2[idx] : tbl1[idx];
    end
    for (int j = 0; j < 4; j++) begin
      o[j] = 0;
      for (int k = 0; k < 4; k++) begin
        case ((k - j) & 3)
          0: cf = 8'h02;
          3: cf = 8'h03;
          default: cf = 8'h01;
        endcase
        o[j] = o[j] ^ b_mul(cf, s[k], p);
      end
    end
    return {o[0], o[1], o[2], o[3]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic step(input bit en, input bit clr, input logic [31:0] s5,
                      input logic [31:0] s15, input string req);
    @(negedge clk_i);
    en_i = en; clear_i = clr; s5_i = s5; s15_i = s15;
    #5;
    chk(req, f_o, (s15 + m1) ^ m2);
    @(posedge clk_i);
    if (clr) begin
      m1 = 0; m2 = 0; m3 = 0;
    end else if (en) begin
      logic [31:0] n1, n2, n3;
      n1 = m2 + (m3 ^ s5);
      n2 = b_box(m1, 1'b0);
      n3 = b_box(m2, 1'b1);
      m1 = n1; m2 = n2; m3 = n3;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      tbl1[i] = b_aes(8'(i));
      tbl2[i] = b_dks(8'(i));
    end
    // reference table spot values
    chk("R6", {24'h0, tbl1[8'h00]}, 32'h63);
    chk("R6", {24'h0, tbl1[8'h53]}, 32'hED);
    chk("R7", {24'h0, tbl2[8'h00]}, 32'h25);
    chk("R7", {24'h0, tbl2[8'h01]}, 32'h24);
    chk("R7", {24'h0, tbl2[8'h02]}, 32'h73);
    chk("R7", {24'h0, tbl2[8'hFF]}, 32'h86);
    m1 = 0; m2 = 0; m3 = 0;
    void'($urandom(32'h1D5E_0C3A));

    repeat (3) @(posedge clk_i);
    #3 rst_ni = 1'b1;
    // R1: state zero after reset, f_o follows s15_i
    step(1'b0, 1'b0, 32'h0, 32'hA5C3_0F71, "R1");
    @(negedge clk_i); s15_i = 32'h1234_5678; #2;
    chk("R1", f_o, 32'h1234_5678);

    // zero taps: known words
    step(1'b1, 1'b0, 0, 0, "R2");
    @(negedge clk_i); en_i = 0; s15_i = 0; s5_i = 0; #5;
    chk("R6 R4", f_o, 32'h6363_6363);
    step(1'b1, 1'b0, 0, 0, "R4");
    @(negedge clk_i); en_i = 0; s15_i = 0; s5_i = 0; #5;
    chk("R7 R5 R3", f_o, 32'hEBEB_EBEB);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 0, 0, "R3 R4 R5");

    // all-ones taps: carry chain and 0xFF table entries
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, '1, '1, "R2 R6 R7");

    // hold with en low
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, $urandom, $urandom, "R8");

    // clear wins over enable
    step(1'b1, 1'b1, $urandom, $urandom, "R9");
    @(negedge clk_i); en_i = 0; clear_i = 0; s15_i = 32'h0BAD_F00D; #5;
    chk("R9", f_o, 32'h0BAD_F00D);

    // single-byte walking s5 to isolate lanes
    for (int i = 0; i < 32; i++) step(1'b1, 1'b0, 32'h1 << i, 32'h0, "R3 R6");

    // random mix
    for (int i = 0; i < 1500; i++) begin
      bit en, clr;
      en  = ($urandom % 4) != 0;
      clr = ($urandom % 64) == 0;
      step(en, clr, $urandom, $urandom, "R2 R3 R4 R5 R8 R9");
    end

    done = 1'b1;
    finish_run();
  end
endmodule